// File: doc/BRIEF.md
# Interrupt Status Aggregator

This block keeps a 32-bit word of pending interrupt causes. Software adds causes by writing any value to a raise register, whose bits are ORed into the word. It removes causes by writing a mask to a separate acknowledge register, which clears every bit set in that mask. Internal engines, such as a computation unit or a memory-copy unit, can OR their own completion codes into the same word. Their requests merge in the same cycle as a software raise.

Two notification styles are offered, selected by `msgMode`. In level mode, which is the default when `msgMode` is low, `irqLevel` stays high for as long as any cause is pending. In message mode, `irqMsgPulse` gives one single-cycle pulse when the word moves from empty to non-empty. In both modes the handler must acknowledge the causes to empty the word. Otherwise no later message can be produced.

Top module: `irq_stat_top`

## Requirements
- R1: After reset the status word is zero, and `irqLevel` and `irqMsgPulse` are low.
- R2: With `busAddr` = 0x24, `busRdData` shows the status word combinationally. Any other address reads zero.
- R3: A write (`busWr` high) to address 0x60 ORs `busWrData` into the status word. The new value appears after the next rising clock edge.
- R4: A write to address 0x64 clears each status bit whose `busWrData` bit is one. The other bits keep their value.
- R5: When an engine set request and a software acknowledge name the same bit in one cycle, the bit ends up set.
- R6: All engine request words in `engSet` (source k occupies bits 32k+31..32k) are ORed into the status word in the same cycle, together with any software raise.
- R7: `irqLevel` is high exactly when the status word is nonzero and `msgMode` is low. It is always low in message mode.
- R8: With `msgMode` high, `irqMsgPulse` is high for exactly one cycle: the first cycle in which the status word is nonzero after a cycle in which it was zero. Further raises while the word stays nonzero give no pulse.
- R9: Writes to any address other than 0x60 and 0x64, including the read-only 0x24, leave the status word unchanged.
- R10: In message mode the status word keeps its pending bits until they are acknowledged through 0x64.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| busWr | input | 1 | Register write strobe |
| busAddr | input | 8 | Register byte address |
| busWrData | input | 32 | Write data |
| busRdData | output | 32 | Read data (combinational) |
| engSet | input | 64 | Engine set requests, 32 bits per source |
| msgMode | input | 1 | 0 = level notification, 1 = message pulse |
| irqLevel | output | 1 | Level interrupt |
| irqMsgPulse | output | 1 | One-cycle message interrupt |

## Verification
The assertions take for granted that a write has only one address per cycle, so a software raise and a software acknowledge never happen together. They also take for granted that the engine inputs are driven to known values in every cycle. The bench changes all inputs only on the falling clock edge and makes one register write per step. Between steps it returns `engSet` to zero, so each clocked property sees one clean cause per cycle. Conflicting requests are formed only between an engine set and a software acknowledge, which is the only conflict the interface allows.

// File: rtl/irq_stat_pkg.sv
package irq_stat_pkg;
  // Strobes from the control decode to the status datapath
  typedef struct packed {
    logic raise;
    logic ack;
    logic rdStat;
  } irqStrobe_t;
endpackage

// File: rtl/irq_stat_ctrl.sv
module irq_stat_ctrl
  import irq_stat_pkg::*;
#(
  parameter int ADDR_W = 8,
  parameter logic [ADDR_W-1:0] STAT_OFS  = 8'h24,
  parameter logic [ADDR_W-1:0] RAISE_OFS = 8'h60,
  parameter logic [ADDR_W-1:0] ACK_OFS   = 8'h64
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              busWr,
  input  logic [ADDR_W-1:0] busAddr,
  input  logic              msgMode,
  input  logic              statNz,
  output irqStrobe_t        stb,
  output logic              irqLevel,
  output logic              irqMsgPulse
);
  logic prevNz;

  always_comb begin
    stb.raise  = busWr && (busAddr == RAISE_OFS);
    stb.ack    = busWr && (busAddr == ACK_OFS);
    stb.rdStat = (busAddr == STAT_OFS);
  end

  // Remembers whether the word was non-empty in the previous cycle
  always_ff @(posedge clk) begin
    if (!rstN) prevNz <= 1'b0;
    else       prevNz <= statNz;
  end

  assign irqLevel    = statNz && !msgMode;
  assign irqMsgPulse = statNz && msgMode && !prevNz;

  // R3/R4: one address per write, so raise and ack never coincide
  a_r3_strobe_excl: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0({stb.raise, stb.ack}));
  // R8: message pulse lasts a single cycle
  a_r8_pulse_single: assert property (@(posedge clk) disable iff (!rstN)
    irqMsgPulse |=> !irqMsgPulse);
  // R8: a pulse follows a cycle with an empty word
  a_r8_pulse_after_empty: assert property (@(posedge clk) disable iff (!rstN)
    irqMsgPulse |-> !$past(statNz));
  // R7: both notifications never active together
  a_r7_mode_excl: assert property (@(posedge clk) disable iff (!rstN)
    !(irqLevel && irqMsgPulse));
endmodule

// File: rtl/irq_stat_dp.sv
module irq_stat_dp
  import irq_stat_pkg::*;
#(
  parameter int STAT_W  = 32,
  parameter int NUM_SRC = 2,
  localparam int SET_W  = STAT_W * NUM_SRC
) (
  input  logic              clk,
  input  logic              rstN,
  input  irqStrobe_t        stb,
  input  logic [STAT_W-1:0] wrData,
  input  logic [SET_W-1:0]  engSet,
  output logic [STAT_W-1:0] rdData,
  output logic              statNz
);
  logic [STAT_W-1:0] status;
  logic [STAT_W-1:0] srcOr [NUM_SRC+1];
  logic [STAT_W-1:0] engAll;
  logic [STAT_W-1:0] setMask;
  logic [STAT_W-1:0] clrMask;

  // OR-reduce engine request words
  assign srcOr[0] = '0;
  for (genvar k = 0; k < NUM_SRC; k++) begin : g_src
    assign srcOr[k+1] = srcOr[k] | engSet[k*STAT_W +: STAT_W];
  end
  assign engAll = srcOr[NUM_SRC];

  assign setMask = engAll | (stb.raise ? wrData : '0);
  assign clrMask = stb.ack ? wrData : '0;

  // Set wins over clear on the same bit
  always_ff @(posedge clk) begin
    if (!rstN) status <= '0;
    else       status <= (status & ~clrMask) | setMask;
  end

  assign statNz = |status;
  assign rdData = stb.rdStat ? status : '0;

  // R3: raised bits are present next cycle
  a_r3_raise_sets: assert property (@(posedge clk) disable iff (!rstN)
    stb.raise |=> ((status & $past(wrData)) == $past(wrData)));
  // R4: acknowledged bits vanish when no engine requests them
  a_r4_ack_clears: assert property (@(posedge clk) disable iff (!rstN)
    (stb.ack && engAll == '0) |=> ((status & $past(wrData)) == '0));
  // R5/R6: engine requests always land, even against an ack
  a_r6_eng_sets: assert property (@(posedge clk) disable iff (!rstN)
    (engAll != '0) |=> ((status & $past(engAll)) == $past(engAll)));
  // R9/R10: without any request the word holds
  a_r9_hold: assert property (@(posedge clk) disable iff (!rstN)
    (!stb.raise && !stb.ack && engAll == '0) |=> $stable(status));
endmodule

// File: rtl/irq_stat_top.sv
module irq_stat_top
  import irq_stat_pkg::*;
#(
  parameter int ADDR_W  = 8,
  parameter int STAT_W  = 32,
  parameter int NUM_SRC = 2,
  localparam int SET_W  = STAT_W * NUM_SRC
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              busWr,
  input  logic [ADDR_W-1:0] busAddr,
  input  logic [STAT_W-1:0] busWrData,
  output logic [STAT_W-1:0] busRdData,
  input  logic [SET_W-1:0]  engSet,
  input  logic              msgMode,
  output logic              irqLevel,
  output logic              irqMsgPulse
);
  irqStrobe_t stb;
  logic       statNz;

  irq_stat_ctrl #(.ADDR_W(ADDR_W)) u_ctrl (
    .clk(clk), .rstN(rstN), .busWr(busWr), .busAddr(busAddr),
    .msgMode(msgMode), .statNz(statNz), .stb(stb),
    .irqLevel(irqLevel), .irqMsgPulse(irqMsgPulse)
  );

  irq_stat_dp #(.STAT_W(STAT_W), .NUM_SRC(NUM_SRC)) u_dp (
    .clk(clk), .rstN(rstN), .stb(stb), .wrData(busWrData),
    .engSet(engSet), .rdData(busRdData), .statNz(statNz)
  );
endmodule

// File: tb/irq_stat_top_tb.sv
module irq_stat_top_tb;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        busWr = 1'b0;
  logic [7:0]  busAddr = 8'h24;
  logic [31:0] busWrData = '0;
  logic [31:0] busRdData;
  logic [63:0] engSet = '0;
  logic        msgMode = 1'b0;
  logic        irqLevel, irqMsgPulse;
  int checks = 0;
  int fails = 0;
  bit done = 1'b0;

  always #4 clk = ~clk;  // 125 MHz

  irq_stat_top u_dut (
    .clk(clk), .rstN(rstN), .busWr(busWr), .busAddr(busAddr),
    .busWrData(busWrData), .busRdData(busRdData), .engSet(engSet),
    .msgMode(msgMode), .irqLevel(irqLevel), .irqMsgPulse(irqMsgPulse)
  );

  typedef struct packed {
    logic        wr;
    logic [7:0]  addr;
    logic [31:0] data;
    logic [31:0] e0;
    logic [31:0] e1;
    logic        mode;
    logic [31:0] expStat;
    logic        expLvl;
  } vec_t;

  localparam vec_t VECS [8] = '{
    '{1'b1, 8'h60, 32'h0000_0011, 32'h0, 32'h0, 1'b0, 32'h0000_0011, 1'b1},          // R3
    '{1'b1, 8'h64, 32'h0000_0001, 32'h0, 32'h0, 1'b0, 32'h0000_0010, 1'b1},          // R4
    '{1'b1, 8'h60, 32'h0000_0100, 32'h2, 32'h8000_0000, 1'b0, 32'h8000_0112, 1'b1},  // R6
    '{1'b1, 8'h20, 32'h0000_FFFF, 32'h0, 32'h0, 1'b0, 32'h8000_0112, 1'b1},          // R9
    '{1'b1, 8'h64, 32'hFFFF_FFFF, 32'h4, 32'h0, 1'b0, 32'h0000_0004, 1'b1},          // R5
    '{1'b1, 8'h64, 32'h0000_0004, 32'h0, 32'h0, 1'b0, 32'h0000_0000, 1'b0},          // R4
    '{1'b1, 8'h24, 32'hFFFF_FFFF, 32'h0, 32'h0, 1'b0, 32'h0000_0000, 1'b0},          // R9
    '{1'b1, 8'h60, 32'hA5A5_0000, 32'h0, 32'h0, 1'b1, 32'hA5A5_0000, 1'b0}           // R7
  };

  task automatic check(input string req, input logic [31:0] got, input logic [31:0] exp);
    checks++;
    if (got !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, got, exp);
    end
  endtask

  // One write at a falling edge, then idle and read status back
  task automatic step(input logic wr, input logic [7:0] addr, input logic [31:0] data,
                      input logic [63:0] eng);
    @(negedge clk);
    busWr = wr; busAddr = addr; busWrData = data; engSet = eng;
    @(negedge clk);
    busWr = 1'b0; busAddr = 8'h24; busWrData = '0; engSet = '0;
    #1;
  endtask

  initial begin
    for (int c = 0; c < 100000 && !done; c++) @(posedge clk);
    if (!done) begin
      checks++; fails++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    #1;
    check("R1 status", busRdData, 32'h0);
    check("R1 level", {31'b0, irqLevel}, 32'h0);
    check("R1 pulse", {31'b0, irqMsgPulse}, 32'h0);
    @(negedge clk);
    rstN = 1'b1;

    for (int i = 0; i < 8; i++) begin
      msgMode = VECS[i].mode;
      step(VECS[i].wr, VECS[i].addr, VECS[i].data, {VECS[i].e1, VECS[i].e0});
      check($sformatf("R3/R4/R5/R6/R9 vec%0d status", i), busRdData, VECS[i].expStat);
      check($sformatf("R7 vec%0d level", i), {31'b0, irqLevel}, {31'b0, VECS[i].expLvl});
    end

    // R2: other address reads zero while status is nonzero
    busAddr = 8'h60; #1;
    check("R2 other addr reads 0", busRdData, 32'h0);
    busAddr = 8'h24; #1;

    // R8 / R10 message mode
    step(1'b1, 8'h64, 32'hFFFF_FFFF, 64'h0);
    check("R8 cleared", busRdData, 32'h0);
    @(negedge clk);
    busWr = 1'b1; busAddr = 8'h60; busWrData = 32'h1;
    @(negedge clk);
    busWr = 1'b0; busAddr = 8'h24; busWrData = '0; #1;
    check("R8 pulse on rise", {31'b0, irqMsgPulse}, 32'h1);
    check("R7 no level in msg mode", {31'b0, irqLevel}, 32'h0);
    @(negedge clk); #1;
    check("R8 pulse one cycle", {31'b0, irqMsgPulse}, 32'h0);
    @(negedge clk);
    busWr = 1'b1; busAddr = 8'h60; busWrData = 32'h2;
    @(negedge clk);
    busWr = 1'b0; busAddr = 8'h24; busWrData = '0; #1;
    check("R8 no pulse while nonzero", {31'b0, irqMsgPulse}, 32'h0);
    repeat (3) @(negedge clk);
    #1;
    check("R10 status held until ack", busRdData, 32'h3);
    step(1'b1, 8'h64, 32'h3, 64'h0);
    check("R10 ack empties", busRdData, 32'h0);
    check("R8 no pulse on clear", {31'b0, irqMsgPulse}, 32'h0);
    // Engine-driven rise also pulses (R6, R8)
    @(negedge clk);
    engSet = 64'h0000_0040_0000_0000;
    @(negedge clk);
    engSet = '0; #1;
    check("R8 pulse from engine", {31'b0, irqMsgPulse}, 32'h1);
    check("R6 engine bit", busRdData, 32'h40);

    // Back to level mode with pending bits
    msgMode = 1'b0; #1;
    check("R7 level in level mode", {31'b0, irqLevel}, 32'h1);
    check("R7 no pulse in level mode", {31'b0, irqMsgPulse}, 32'h0);

    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule